// File: doc/BRIEF.md
# Processor-Side Memory Transfer Sequencer

This block sits between a processor core and main memory and carries out one read or one write at a time. A request is accepted only while the sequencer is idle. The sequencer first latches the target address into an internal address register and, for a write, latches the outgoing data into an internal data register. It drives the address onto the memory bus for one full cycle before it raises either strobe. It then holds the read or write strobe until the memory reports completion, or until a fixed cycle budget runs out on memories that have no completion line. It ends the transfer with a one-cycle done pulse.

Read data is captured into the data register at completion, and the requester reads it from there. The parameter `USE_ACK` chooses the completion source. When the acknowledge line is in use, an optional watchdog ends a transfer that never receives an acknowledge and reports the failure on a separate flag. The completion source and the watchdog are fixed when the design is elaborated.

Top module: `mem_xfer_unit`

## Requirements
- R1: A synchronous active-high reset clears the address register (`mem_addr` reads 0) and the data register (`req_rdata` reads 0). It drops both strobes and both `req_done` and `req_err`, and leaves the sequencer idle.
- R2: For a read, the address sampled with `req_start` appears on `mem_addr` one cycle after the start edge, with both strobes low. `mem_rd` rises one cycle later, and the address stays unchanged while `mem_rd` is high.
- R3: For a write (`req_write`=1), `mem_addr` and `mem_wdata` carry the requested address and data one cycle before `mem_wr` rises, and both stay stable while `mem_wr` is high. After the write, `req_rdata` shows the written data, because it mirrors the data register.
- R4: In acknowledge mode, a strobe stays high until `mem_ack` is sampled high while the strobe is high. In the next cycle both strobes are low and `req_done` is high for exactly one cycle.
- R5: If `mem_ack` is already high in the first strobe cycle, the transfer completes after exactly one strobe cycle.
- R6: At read completion, the value of `mem_rdata` sampled with the acknowledge is stored in the data register. It is visible on `req_rdata` from the done cycle onward.
- R7: With `USE_ACK`=0, every strobe lasts exactly `FIXED_WAIT` cycles, whatever `mem_ack` does. The transfer then completes as in R4.
- R8: `mem_rd` and `mem_wr` are never high in the same cycle.
- R9: A `req_start` that arrives while a transfer is in progress is ignored. The address, data and direction of the current transfer do not change, and exactly one done pulse results.
- R10: In acknowledge mode with the watchdog enabled, a strobe that sees no acknowledge for `WDOG_MAX` cycles is dropped. `req_err` then pulses for one cycle without `req_done`, and the sequencer returns to idle. An acknowledge in the `WDOG_MAX`-th cycle still completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start a transfer (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read, sampled with req_start |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | One-cycle watchdog abort pulse |
| req_rdata | output | DATA_W | Data register contents |
| mem_addr | output | ADDR_W | Address bus (address register) |
| mem_wdata | output | DATA_W | Write data bus (data register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | DATA_W | Read data bus from memory |
| mem_ack | input | 1 | Memory function complete |

## Verification
A corrupted sequencer state shows up at the ports within one or two cycles of the start edge. Possible symptoms are a strobe that rises together with the address instead of one cycle after it, a strobe whose length differs from the acknowledge latency or the fixed budget, a missing or doubled done pulse, or the wrong strobe for the requested direction. A corrupted address or data register shows up on `mem_addr` or `mem_wdata` while the strobe is high. It also shows up on `req_rdata` from the done cycle onward. Sweeping every address in both directions, across several acknowledge latencies, exposes each of these within the transfer that causes them.

// File: rtl/mxu_pkg.sv
package mxu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } mxu_state_t;
endpackage

// File: rtl/mxu_regs.sv
module mxu_regs #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          load_wr,
  input  logic          capture,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] rdata_in,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mdr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
      mdr <= '0;
    end else begin
      if (load) begin
        mar <= addr_in;
        if (load_wr) mdr <= wdata_in;
      end
      if (capture) mdr <= rdata_in;
    end
  end
endmodule

// File: rtl/mxu_cnt.sv
module mxu_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mxu_seq.sv
module mxu_seq
  import mxu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       write,
  input  logic       finish,
  input  logic       abort,
  output mxu_state_t state,
  output logic       load,
  output logic       capture,
  output logic       cnt_clr,
  output logic       rd_o,
  output logic       wr_o,
  output logic       done_o,
  output logic       err_o
);
  logic is_wr;

  always_comb begin
    load    = (state == ST_IDLE) && start;
    capture = (state == ST_WAIT) && finish && !is_wr;
    cnt_clr = (state != ST_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      is_wr  <= 1'b0;
      rd_o   <= 1'b0;
      wr_o   <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          is_wr <= write;
          state <= ST_SETUP;
        end
        ST_SETUP: begin
          rd_o  <= !is_wr;
          wr_o  <= is_wr;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (finish) begin
            rd_o   <= 1'b0;
            wr_o   <= 1'b0;
            done_o <= 1'b1;
            state  <= ST_DONE;
          end else if (abort) begin
            rd_o  <= 1'b0;
            wr_o  <= 1'b0;
            err_o <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mem_xfer_unit.sv
module mem_xfer_unit
  import mxu_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter bit USE_ACK    = 1'b1,
  parameter int FIXED_WAIT = 3,
  parameter bit WDOG_EN    = 1'b1,
  parameter int WDOG_MAX   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_done,
  output logic              req_err,
  output logic [DATA_W-1:0] req_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int CMAX  = (FIXED_WAIT > WDOG_MAX) ? FIXED_WAIT : WDOG_MAX;
  localparam int CNT_W = $clog2(CMAX + 1);

  mxu_state_t       state;
  logic             load, capture, cnt_clr, finish, abort;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr;

  generate
    if (USE_ACK) begin : g_ack
      assign finish = mem_ack;
      if (WDOG_EN) begin : g_wdog
        assign abort = (cnt == CNT_W'(WDOG_MAX - 1));
      end else begin : g_nowdog
        assign abort = 1'b0;
      end
    end else begin : g_fixed
      assign finish = (cnt == CNT_W'(FIXED_WAIT - 1));
      assign abort  = 1'b0;
    end
  endgenerate

  mxu_seq u_seq (
    .clk(clk), .rst(rst), .start(req_start), .write(req_write),
    .finish(finish), .abort(abort), .state(state), .load(load),
    .capture(capture), .cnt_clr(cnt_clr), .rd_o(mem_rd), .wr_o(mem_wr),
    .done_o(req_done), .err_o(req_err)
  );

  mxu_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .cnt(cnt)
  );

  mxu_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .load(load), .load_wr(req_write),
    .capture(capture), .addr_in(req_addr), .wdata_in(req_wdata),
    .rdata_in(mem_rdata), .mar(mar), .mdr(mdr)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign req_rdata = mdr;
endmodule

// File: rtl/mxu_checker.sv
module mxu_checker #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter bit USE_ACK = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_done,
  input logic              req_err,
  input logic [DATA_W-1:0] req_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ack
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!mem_rd && !mem_wr && !req_done && !req_err &&
             mem_addr == '0 && req_rdata == '0));

  p_addr_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd || mem_wr) |-> $stable(mem_addr));

  p_bus_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |=> (!(mem_rd || mem_wr) ||
                            ($stable(mem_addr) && $stable(mem_wdata))));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);

  p_done_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    req_done |-> (!mem_rd && !mem_wr));

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_err_alone_r10: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!req_done && !mem_rd && !mem_wr));

  generate
    if (USE_ACK) begin : g_ack_chk
      p_ack_ends_r5: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && mem_ack) |=> (req_done && !mem_rd && !mem_wr));
    end
  endgenerate
endmodule

bind mem_xfer_unit mxu_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .USE_ACK(USE_ACK)
) u_chk (
  .clk(clk), .rst(rst), .req_done(req_done), .req_err(req_err),
  .req_rdata(req_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ack(mem_ack)
);

// File: tb/mem_xfer_unit_test.sv
`timescale 1ns/1ps
module mem_xfer_unit_test;
  localparam int WD = 8;
  localparam int FW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       start = 0, wr_i = 0, ack_i = 0, sel = 0;
  logic [7:0] addr_i = 0, wdata_i = 0;

  logic       a_done, a_err, a_rd, a_wr;
  logic [7:0] a_rdata, a_addr, a_wdata, a_mrd;
  logic       f_done, f_err, f_rd, f_wr;
  logic [7:0] f_rdata, f_addr, f_wdata, f_mrd;

  function automatic logic [7:0] memf(input logic [7:0] a);
    return 8'(a * 8'd37 + 8'd11);
  endfunction

  assign a_mrd = memf(a_addr);
  assign f_mrd = memf(f_addr);

  mem_xfer_unit #(.USE_ACK(1'b1), .WDOG_EN(1'b1), .WDOG_MAX(WD)) uut (
    .clk(clk), .rst(rst), .req_start(start && !sel), .req_write(wr_i),
    .req_addr(addr_i), .req_wdata(wdata_i), .req_done(a_done), .req_err(a_err),
    .req_rdata(a_rdata), .mem_addr(a_addr), .mem_wdata(a_wdata),
    .mem_rd(a_rd), .mem_wr(a_wr), .mem_rdata(a_mrd), .mem_ack(ack_i)
  );

  mem_xfer_unit #(.USE_ACK(1'b0), .FIXED_WAIT(FW)) uut_fx (
    .clk(clk), .rst(rst), .req_start(start && sel), .req_write(wr_i),
    .req_addr(addr_i), .req_wdata(wdata_i), .req_done(f_done), .req_err(f_err),
    .req_rdata(f_rdata), .mem_addr(f_addr), .mem_wdata(f_wdata),
    .mem_rd(f_rd), .mem_wr(f_wr), .mem_rdata(f_mrd), .mem_ack(ack_i)
  );

  logic       o_done, o_err, o_rd, o_wr;
  logic [7:0] o_rdata, o_addr, o_wdata;
  assign o_done  = sel ? f_done  : a_done;
  assign o_err   = sel ? f_err   : a_err;
  assign o_rd    = sel ? f_rd    : a_rd;
  assign o_wr    = sel ? f_wr    : a_wr;
  assign o_rdata = sel ? f_rdata : a_rdata;
  assign o_addr  = sel ? f_addr  : a_addr;
  assign o_wdata = sel ? f_wdata : a_wdata;

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One transfer; lat = strobe cycle in which ack is raised (ack-mode).
  task automatic xfer(input bit s, input bit w, input logic [7:0] a,
                      input logic [7:0] d, input int lat, input bit poke,
                      input bit early);
    int scnt = 0, dcnt = 0, ecnt = 0, first = -1, fin = -1;
    bit bus_ok = 1, dir_ok = 1, excl_ok = 1, after_ok = 1;
    logic [7:0] rd_done = 0;
    int exp_s;
    bit exp_done;
    @(negedge clk);
    sel = s; start = 1; wr_i = w; addr_i = a; wdata_i = d; ack_i = early;
    @(negedge clk);
    start = 0;
    // R2/R3: setup cycle, address (and write data) present, strobes low
    chk(o_addr == a && !o_rd && !o_wr, "R2 setup address", o_addr, a);
    if (w) chk(o_wdata == d, "R3 setup wdata", o_wdata, d);
    if (poke) begin
      start = 1; wr_i = !w; addr_i = ~a; wdata_i = ~d;
    end
    for (int cyc = 1; cyc < 60; cyc++) begin
      @(negedge clk);
      start = 0;
      if (fin >= 0) begin
        after_ok = !o_rd && !o_wr && !o_done && !o_err;
        break;
      end
      if (o_rd && o_wr) excl_ok = 0;
      if (o_rd || o_wr) begin
        scnt++;
        if (first < 0) first = cyc;
        if (o_wr != w || o_rd != !w) dir_ok = 0;
        if (o_addr != a || (w && o_wdata != d)) bus_ok = 0;
        if (scnt >= lat) ack_i = 1;
      end
      if (o_done) begin dcnt++; rd_done = o_rdata; fin = cyc; ack_i = 0; end
      if (o_err)  begin ecnt++; fin = cyc; ack_i = 0; end
    end
    ack_i = 0;
    exp_s    = s ? FW : ((lat <= WD) ? lat : WD);
    exp_done = s || (lat <= WD);
    chk(first == 1, "R2 strobe one cycle after setup", first, 1);
    chk(dir_ok, "R2/R3 strobe direction", dir_ok, 1);
    chk(bus_ok, poke ? "R9 busy start ignored, bus stable" : "R3 bus stable during strobe", bus_ok, 1);
    chk(excl_ok, "R8 strobes exclusive", excl_ok, 1);
    chk(scnt == exp_s, s ? "R7 fixed strobe length" : (lat <= WD ? "R4 strobe length" : "R10 watchdog length"), scnt, exp_s);
    chk(dcnt == (exp_done ? 1 : 0), poke ? "R9 single done" : "R4 done count", dcnt, exp_done ? 1 : 0);
    chk(ecnt == (exp_done ? 0 : 1), "R10 error pulse", ecnt, exp_done ? 0 : 1);
    chk(after_ok, "R4 one-cycle pulse, strobes low after", after_ok, 1);
    if (exp_done) begin
      if (w) chk(rd_done == d, "R3 rdata mirrors written data", rd_done, d);
      else   chk(rd_done == memf(a), "R6 read data captured", rd_done, memf(a));
      chk(o_rdata == rd_done, "R6 rdata held after done", o_rdata, rd_done);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state of both instances
    chk(a_addr == 0 && f_addr == 0, "R1 address cleared", a_addr, 0);
    chk(a_rdata == 0 && f_rdata == 0, "R1 data cleared", a_rdata, 0);
    chk(!a_rd && !a_wr && !f_rd && !f_wr, "R1 strobes low", a_rd, 0);
    chk(!a_done && !a_err && !f_done && !f_err, "R1 done/err low", a_done, 0);
    rst = 0;
    // near-exhaustive sweep: every address, both directions, latencies 1..4
    for (int a = 0; a < 256; a++) begin
      xfer(0, 0, 8'(a), 8'h00, (a % 4) + 1, 0, 0);
      xfer(0, 1, 8'(a), 8'(a ^ 8'h5A), ((a >> 2) % 4) + 1, 0, 0);
    end
    // R5: ack already high before the strobe rises
    xfer(0, 0, 8'h3C, 8'h00, 1, 0, 1);
    xfer(0, 1, 8'hC3, 8'h77, 1, 0, 1);
    // R10 boundary: ack in the last allowed cycle, then no ack at all
    xfer(0, 0, 8'h21, 8'h00, WD, 0, 0);
    xfer(0, 0, 8'h42, 8'h00, WD + 5, 0, 0);
    xfer(0, 1, 8'h43, 8'h99, 100, 0, 0);
    // R10: usable again after an abort
    xfer(0, 0, 8'h44, 8'h00, 2, 0, 0);
    // R9: start while busy
    xfer(0, 0, 8'h55, 8'h00, 3, 1, 0);
    xfer(0, 1, 8'h66, 8'hAB, 2, 1, 0);
    // R7: fixed-delay instance, ack early, ack late, ack never
    for (int a = 0; a < 64; a++) begin
      xfer(1, a[0], 8'(a * 5), 8'(a + 9), 1, 0, a[1]);
      xfer(1, !a[0], 8'(a * 3), 8'(a ^ 8'hF0), 100, 0, 0);
    end
    xfer(1, 0, 8'h10, 8'h00, 3, 1, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule